// File: doc/BRIEF.md
# Register-Based Page Translation Unit

This block turns a 16-bit virtual address into a 15-bit physical address. The page table sits entirely in flip-flops inside the block, with one entry for each virtual page. The entry is selected directly by the page number, so a translation never waits on a memory read. Each entry holds a frame number, a present flag, a used (referenced) flag, a dirty (modified) flag and an uncached flag.

Software fills entries through a load port and can read any entry back through a peek port. The address path looks up the entry combinationally. On the clock edge of a valid access it marks the entry used, and also dirty when the access is a write. An access to a page that is not present yields no address and raises a fault. The block records the page number and access kind of the first such fault until software clears it. A sweep input wipes every used flag in one cycle, for a periodic tick.

Top module: `page_xlate_unit`

## Requirements
- R1: The upper 4 bits of `xl_vaddr` select the page and the lower 12 bits pass unchanged into `xl_paddr[11:0]`. `xl_paddr[14:12]` is the 3-bit frame number of the selected entry.
- R2: With page 0 mapped to frame 2, address 0 gives 8192. With page 2 mapped to frame 6, address 8192 gives 24576 and address 8196 gives 24580.
- R3: A valid access to a page whose present flag is 0 (for example address 32780, page 8) drives `xl_fault`=1, `xl_paddr`=0 and `xl_nocache`=0. It changes no used or dirty flag.
- R4: On the edge of a faulting access, while no fault is pending, `flt_pending` rises and `flt_vpn`/`flt_write` capture the page and the access kind (1 = write). Later faults do not change them while one is pending.
- R5: `flt_clear` drops `flt_pending` on the next edge. If a fault arrives in the same cycle as the clear, that new fault is captured instead.
- R6: A valid, translated read sets the entry's used flag on the clock edge and leaves its dirty flag unchanged.
- R7: A valid, translated write sets both the used and the dirty flag of the entry.
- R8: `xl_nocache` equals the uncached flag of the selected present entry.
- R9: `tick_clr_ref` clears every used flag in one cycle and leaves the dirty flags alone. A translated access in the same cycle still sets its own used flag.
- R10: A load writes the frame, present and uncached fields and clears that entry's used and dirty flags. A load takes priority over a same-cycle access to the same entry.
- R11: With `xl_valid` low, `xl_fault` stays 0 and neither usage flags nor fault state change.
- R12: After reset every entry is not present with used and dirty flags 0, and no fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one page-table entry |
| ld_vpn | input | 4 | Page number of the entry to write |
| ld_frame | input | 3 | Frame number to store |
| ld_present | input | 1 | Present flag to store |
| ld_nocache | input | 1 | Uncached flag to store |
| tick_clr_ref | input | 1 | Clear all used flags |
| xl_valid | input | 1 | An access is presented |
| xl_vaddr | input | 16 | Virtual address |
| xl_write | input | 1 | Access is a write |
| xl_paddr | output | 15 | Translated physical address |
| xl_fault | output | 1 | Page not present |
| xl_nocache | output | 1 | Uncached attribute of the page |
| flt_clear | input | 1 | Release the recorded fault |
| flt_pending | output | 1 | A fault is recorded |
| flt_vpn | output | 4 | Page number of the recorded fault |
| flt_write | output | 1 | Recorded fault was a write |
| peek_vpn | input | 4 | Entry to read back |
| peek_frame | output | 3 | Frame field of that entry |
| peek_present | output | 1 | Present flag of that entry |
| peek_ref | output | 1 | Used flag of that entry |
| peek_mod | output | 1 | Dirty flag of that entry |
| peek_nocache | output | 1 | Uncached flag of that entry |

## Verification
The bound checker watches every cycle for several properties. A fault must never carry an address. The offset must pass through on every translation. A translated access must leave its entry's used flag set, and a write must also leave the dirty flag set. A lone sweep must empty the used flags, and the fault record must be captured, held and released correctly. The bench scenarios cover what needs a specific table state. These are the numeric example mappings, the uncached attribute, the load-versus-access priority, the sweep coinciding with an access, the clear-with-new-fault case and the reset contents read back through the peek port.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_kind_e;

   function automatic logic is_write(input acc_kind_e k);
      return k == ACC_WR;
   endfunction
endpackage

// File: rtl/pxu_entry.sv
`timescale 1ns/1ps
module pxu_entry #(
   parameter int FRAME_W = 3,
   parameter bit KEEP_NC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_hit,
   input  logic [FRAME_W-1:0] ld_frame,
   input  logic               ld_present,
   input  logic               ld_nocache,
   input  logic               acc_hit,
   input  logic               acc_wr,
   input  logic               clr_ref,
   output logic [FRAME_W-1:0] e_frame,
   output logic               e_present,
   output logic               e_ref,
   output logic               e_mod,
   output logic               e_nocache
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_frame   <= '0;
         e_present <= 1'b0;
         e_ref     <= 1'b0;
         e_mod     <= 1'b0;
      end else if (ld_hit) begin
         e_frame   <= ld_frame;
         e_present <= ld_present;
         e_ref     <= 1'b0;
         e_mod     <= 1'b0;
      end else begin
         if (acc_hit) begin
            e_ref <= 1'b1;
            if (acc_wr) e_mod <= 1'b1;
         end else if (clr_ref) begin
            e_ref <= 1'b0;
         end
      end
   end

   generate
      if (KEEP_NC) begin : g_nc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      e_nocache <= 1'b0;
            else if (ld_hit) e_nocache <= ld_nocache;
         end
      end else begin : g_no_nc
         logic unused_nc;
         assign unused_nc = ld_nocache;
         assign e_nocache = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pxu_lookup.sv
`timescale 1ns/1ps
module pxu_lookup #(
   parameter int VPN_W   = 4,
   parameter int OFS_W   = 12,
   parameter int FRAME_W = 3,
   localparam int N_PAGES = 1 << VPN_W,
   localparam int PA_W    = FRAME_W + OFS_W
) (
   input  logic [N_PAGES-1:0][FRAME_W-1:0] frames,
   input  logic [N_PAGES-1:0]              present,
   input  logic [N_PAGES-1:0]              nocache,
   input  logic                            valid,
   input  logic [VPN_W-1:0]                vpn,
   input  logic [OFS_W-1:0]                ofs,
   output logic [PA_W-1:0]                 paddr,
   output logic                            fault,
   output logic                            hit,
   output logic                            nc
);
   logic sel_present;
   assign sel_present = present[vpn];
   assign hit   = valid & sel_present;
   assign fault = valid & ~sel_present;

   always_comb begin
      if (sel_present) begin
         paddr = {frames[vpn], ofs};
         nc    = nocache[vpn];
      end else begin
         paddr = '0;
         nc    = 1'b0;
      end
   end
endmodule

// File: rtl/pxu_fault_latch.sv
`timescale 1ns/1ps
module pxu_fault_latch
   import pxu_pkg::*;
#(
   parameter int VPN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault_in,
   input  logic [VPN_W-1:0] vpn_in,
   input  acc_kind_e        kind_in,
   input  logic             clr,
   output logic             pending,
   output logic [VPN_W-1:0] vpn_q,
   output logic             wr_q
);
   logic take;
   assign take = fault_in & (~pending | clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         vpn_q   <= '0;
         wr_q    <= 1'b0;
      end else if (take) begin
         pending <= 1'b1;
         vpn_q   <= vpn_in;
         wr_q    <= is_write(kind_in);
      end else if (clr) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/page_xlate_unit.sv
`timescale 1ns/1ps
module page_xlate_unit
   import pxu_pkg::*;
#(
   parameter int VA_W    = 16,
   parameter int OFS_W   = 12,
   parameter int FRAME_W = 3,
   parameter bit KEEP_NC = 1'b1,
   localparam int VPN_W   = VA_W - OFS_W,
   localparam int N_PAGES = 1 << VPN_W,
   localparam int PA_W    = FRAME_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [VPN_W-1:0]   ld_vpn,
   input  logic [FRAME_W-1:0] ld_frame,
   input  logic               ld_present,
   input  logic               ld_nocache,
   input  logic               tick_clr_ref,
   input  logic               xl_valid,
   input  logic [VA_W-1:0]    xl_vaddr,
   input  logic               xl_write,
   output logic [PA_W-1:0]    xl_paddr,
   output logic               xl_fault,
   output logic               xl_nocache,
   input  logic               flt_clear,
   output logic               flt_pending,
   output logic [VPN_W-1:0]   flt_vpn,
   output logic               flt_write,
   input  logic [VPN_W-1:0]   peek_vpn,
   output logic [FRAME_W-1:0] peek_frame,
   output logic               peek_present,
   output logic               peek_ref,
   output logic               peek_mod,
   output logic               peek_nocache
);
   generate
      if (VA_W <= OFS_W)   begin : g_bad_va  $error("VA_W must exceed OFS_W");    end
      if (VPN_W > 8)       begin : g_bad_vpn $error("page count too large");      end
      if (FRAME_W < 1)     begin : g_bad_fr  $error("FRAME_W must be positive");  end
      if (OFS_W < 1)       begin : g_bad_of  $error("OFS_W must be positive");    end
   endgenerate

   logic [VPN_W-1:0] acc_vpn;
   logic [OFS_W-1:0] acc_ofs;
   assign acc_vpn = xl_vaddr[VA_W-1:OFS_W];
   assign acc_ofs = xl_vaddr[OFS_W-1:0];

   logic [N_PAGES-1:0][FRAME_W-1:0] frame_vec;
   logic [N_PAGES-1:0] present_vec;
   logic [N_PAGES-1:0] ref_vec;
   logic [N_PAGES-1:0] mod_vec;
   logic [N_PAGES-1:0] nc_vec;
   logic               acc_ok;

   for (genvar i = 0; i < N_PAGES; i++) begin : g_entry
      logic ld_hit_i;
      logic acc_hit_i;
      assign ld_hit_i  = ld_en  && (ld_vpn  == VPN_W'(i));
      assign acc_hit_i = acc_ok && (acc_vpn == VPN_W'(i));
      pxu_entry #(.FRAME_W(FRAME_W), .KEEP_NC(KEEP_NC)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld_hit    (ld_hit_i),
         .ld_frame  (ld_frame),
         .ld_present(ld_present),
         .ld_nocache(ld_nocache),
         .acc_hit   (acc_hit_i),
         .acc_wr    (xl_write),
         .clr_ref   (tick_clr_ref),
         .e_frame   (frame_vec[i]),
         .e_present (present_vec[i]),
         .e_ref     (ref_vec[i]),
         .e_mod     (mod_vec[i]),
         .e_nocache (nc_vec[i])
      );
   end

   pxu_lookup #(.VPN_W(VPN_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W)) u_look (
      .frames (frame_vec),
      .present(present_vec),
      .nocache(nc_vec),
      .valid  (xl_valid),
      .vpn    (acc_vpn),
      .ofs    (acc_ofs),
      .paddr  (xl_paddr),
      .fault  (xl_fault),
      .hit    (acc_ok),
      .nc     (xl_nocache)
   );

   acc_kind_e acc_kind;
   assign acc_kind = xl_write ? ACC_WR : ACC_RD;

   pxu_fault_latch #(.VPN_W(VPN_W)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault_in(xl_fault),
      .vpn_in  (acc_vpn),
      .kind_in (acc_kind),
      .clr     (flt_clear),
      .pending (flt_pending),
      .vpn_q   (flt_vpn),
      .wr_q    (flt_write)
   );

   assign peek_frame   = frame_vec[peek_vpn];
   assign peek_present = present_vec[peek_vpn];
   assign peek_ref     = ref_vec[peek_vpn];
   assign peek_mod     = mod_vec[peek_vpn];
   assign peek_nocache = nc_vec[peek_vpn];
endmodule

// File: rtl/pxu_checker.sv
`timescale 1ns/1ps
module pxu_checker #(
   parameter int VA_W    = 16,
   parameter int OFS_W   = 12,
   parameter int PA_W    = 15,
   parameter int VPN_W   = 4,
   parameter int N_PAGES = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_en,
   input logic [VPN_W-1:0]   ld_vpn,
   input logic               tick_clr_ref,
   input logic               xl_valid,
   input logic [VA_W-1:0]    xl_vaddr,
   input logic               xl_write,
   input logic [PA_W-1:0]    xl_paddr,
   input logic               xl_fault,
   input logic               xl_nocache,
   input logic               flt_clear,
   input logic               flt_pending,
   input logic [VPN_W-1:0]   flt_vpn,
   input logic [N_PAGES-1:0] ref_vec,
   input logic [N_PAGES-1:0] mod_vec
);
   logic [VPN_W-1:0] vpn;
   logic             ld_same;
   assign vpn     = xl_vaddr[VA_W-1:OFS_W];
   assign ld_same = ld_en && (ld_vpn == vpn);

   p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xl_fault |-> (xl_paddr == '0) && !xl_nocache);

   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_fault) |-> (xl_paddr[OFS_W-1:0] == xl_vaddr[OFS_W-1:0]));

   p_no_fault_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |-> !xl_fault);

   p_ref_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_fault && !ld_same) |=> ref_vec[$past(vpn)]);

   p_mod_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_fault && xl_write && !ld_same) |=> mod_vec[$past(vpn)]);

   p_sweep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_clr_ref && !xl_valid && !ld_en) |=> (ref_vec == '0));

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_fault && !flt_pending) |=> flt_pending && (flt_vpn == $past(vpn)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_pending && !flt_clear) |=> flt_pending && $stable(flt_vpn));

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_clear && !xl_fault) |=> !flt_pending);
endmodule

bind page_xlate_unit pxu_checker #(
   .VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .VPN_W(VPN_W), .N_PAGES(N_PAGES)
) u_pxu_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_en       (ld_en),
   .ld_vpn      (ld_vpn),
   .tick_clr_ref(tick_clr_ref),
   .xl_valid    (xl_valid),
   .xl_vaddr    (xl_vaddr),
   .xl_write    (xl_write),
   .xl_paddr    (xl_paddr),
   .xl_fault    (xl_fault),
   .xl_nocache  (xl_nocache),
   .flt_clear   (flt_clear),
   .flt_pending (flt_pending),
   .flt_vpn     (flt_vpn),
   .ref_vec     (ref_vec),
   .mod_vec     (mod_vec)
);

// File: tb/page_xlate_unit_test.sv
`timescale 1ns/1ps
module page_xlate_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_vpn = '0;
   logic [2:0]  ld_frame = '0;
   logic        ld_present = 1'b0;
   logic        ld_nocache = 1'b0;
   logic        tick_clr_ref = 1'b0;
   logic        xl_valid = 1'b0;
   logic [15:0] xl_vaddr = '0;
   logic        xl_write = 1'b0;
   logic [14:0] xl_paddr;
   logic        xl_fault;
   logic        xl_nocache;
   logic        flt_clear = 1'b0;
   logic        flt_pending;
   logic [3:0]  flt_vpn;
   logic        flt_write;
   logic [3:0]  peek_vpn = '0;
   logic [2:0]  peek_frame;
   logic        peek_present, peek_ref, peek_mod, peek_nocache;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   page_xlate_unit uut (.*);

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ld_en = 0; xl_valid = 0; xl_write = 0; tick_clr_ref = 0; flt_clear = 0;
   endtask

   task automatic load(input int vpn, input int fr, input bit pr, input bit nc);
      ld_en = 1; ld_vpn = 4'(vpn); ld_frame = 3'(fr); ld_present = pr; ld_nocache = nc;
      step();
      ld_en = 0;
   endtask

   task automatic t_reset();
      for (int p = 0; p < 16; p++) begin
         peek_vpn = 4'(p); #0.5;
         chk("R12 present", peek_present, 0);
         chk("R12 used", peek_ref, 0);
         chk("R12 dirty", peek_mod, 0);
      end
      chk("R12 pending", flt_pending, 0);
   endtask

   task automatic t_examples();
      load(0, 2, 1, 0);
      load(2, 6, 1, 0);
      load(5, 7, 1, 1);
      xl_valid = 1; xl_write = 0; xl_vaddr = 16'd0; #0.5;
      chk("R2 0->8192", xl_paddr, 8192);
      chk("R2 no fault", xl_fault, 0);
      step();
      xl_vaddr = 16'd8192; #0.5;
      chk("R2 8192->24576", xl_paddr, 24576);
      step();
      xl_vaddr = 16'd8196; #0.5;
      chk("R2 8196->24580", xl_paddr, 24580);
      xl_vaddr = 16'h2ABC; #0.5;
      chk("R1 offset join", xl_paddr, (6 << 12) | 'hABC);
      step();
      idle();
      peek_vpn = 0; #0.5;
      chk("R6 used after read", peek_ref, 1);
      chk("R6 read keeps clean", peek_mod, 0);
      peek_vpn = 2; #0.5;
      chk("R6 used page 2", peek_ref, 1);
      chk("R6 page 2 clean", peek_mod, 0);
   endtask

   task automatic t_write();
      xl_valid = 1; xl_write = 1; xl_vaddr = 16'd8196;
      step();
      idle();
      peek_vpn = 2; #0.5;
      chk("R7 dirty after write", peek_mod, 1);
      chk("R7 used after write", peek_ref, 1);
   endtask

   task automatic t_nocache();
      xl_valid = 1; xl_vaddr = 16'h5123; #0.5;
      chk("R8 uncached page", xl_nocache, 1);
      chk("R8 paddr", xl_paddr, 16'h7123);
      xl_vaddr = 16'h0010; #0.5;
      chk("R8 cached page", xl_nocache, 0);
      idle(); #0.5;
   endtask

   task automatic t_fault();
      xl_valid = 1; xl_write = 1; xl_vaddr = 16'd32780; #0.5;
      chk("R3 fault", xl_fault, 1);
      chk("R3 no address", xl_paddr, 0);
      chk("R3 no uncached", xl_nocache, 0);
      step();
      xl_write = 0; xl_vaddr = 16'h3000;
      chk("R4 pending", flt_pending, 1);
      chk("R4 vpn", flt_vpn, 8);
      chk("R4 kind", flt_write, 1);
      step();
      chk("R4 held vpn", flt_vpn, 8);
      chk("R4 held kind", flt_write, 1);
      xl_vaddr = 16'h4000; flt_clear = 1;
      step();
      chk("R5 clear+new pending", flt_pending, 1);
      chk("R5 clear+new vpn", flt_vpn, 4);
      chk("R5 clear+new kind", flt_write, 0);
      xl_valid = 0;
      step();
      idle();
      chk("R5 released", flt_pending, 0);
      peek_vpn = 8; #0.5;
      chk("R3 no used flag", peek_ref, 0);
      chk("R3 no dirty flag", peek_mod, 0);
   endtask

   task automatic t_idle_access();
      xl_valid = 0; xl_vaddr = 16'h9000; xl_write = 1; #0.5;
      chk("R11 no fault", xl_fault, 0);
      xl_vaddr = 16'h5000;
      step();
      chk("R11 no pending", flt_pending, 0);
      idle();
      peek_vpn = 5; #0.5;
      chk("R11 page untouched", peek_ref, 0);
   endtask

   task automatic t_sweep();
      xl_valid = 1; xl_write = 0; xl_vaddr = 16'h5000; tick_clr_ref = 1;
      step();
      idle();
      peek_vpn = 0; #0.5; chk("R9 page 0 swept", peek_ref, 0);
      peek_vpn = 2; #0.5; chk("R9 page 2 swept", peek_ref, 0);
      chk("R9 dirty kept", peek_mod, 1);
      peek_vpn = 5; #0.5; chk("R9 access wins", peek_ref, 1);
   endtask

   task automatic t_load_prio();
      xl_valid = 1; xl_write = 1; xl_vaddr = 16'h2000;
      ld_en = 1; ld_vpn = 2; ld_frame = 1; ld_present = 1; ld_nocache = 0; #0.5;
      chk("R10 old mapping used", xl_paddr, 24576);
      step();
      idle();
      peek_vpn = 2; #0.5;
      chk("R10 frame", peek_frame, 1);
      chk("R10 used cleared", peek_ref, 0);
      chk("R10 dirty cleared", peek_mod, 0);
      chk("R10 present", peek_present, 1);
      xl_valid = 1; xl_vaddr = 16'h2004; #0.5;
      chk("R10 new mapping", xl_paddr, (1 << 12) | 4);
      idle();
   endtask

   initial begin
      #1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_examples();
      t_write();
      t_nocache();
      t_fault();
      t_idle_access();
      t_sweep();
      t_load_prio();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule